// File: doc/BRIEF.md
# Lockable Paired GPIO Port Controller

This block manages two 8-bit general-purpose I/O ports through a small synchronous register bus. Every pin has its own settings for direction, drive value, pull resistor enable, interrupt enable and interrupt edge polarity. Pin inputs are brought into the clock domain through a two-stage synchronizer. A rising or falling transition, whichever is selected, sets a sticky per-pin flag that software clears by writing a one to it. A single interrupt line is asserted while any flagged pin also has its interrupt enabled.

Each register is 16 bits wide. The low byte belongs to port A and the high byte to port B, so software can reach one port with a single byte enable or both ports with one word access. Coming out of reset, the controller holds every pad high-impedance with pulls off and ignores pin transitions. Software may load the configuration registers during this time. The settings only reach the pads once software clears the lock bit, and after that the lock cannot be set again until the next reset.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset, pin_oe, pin_out, pin_pull_en and pin_pull_up are all 0, irq is 0, every configuration and flag register reads 0, and the control register (word address 7) reads 1 in bit 0, which is the lock bit.
- R2: While locked, writes to the configuration registers are stored and read back, but pin_oe, pin_out, pin_pull_en and pin_pull_up stay 0.
- R3: Writing 1 to bit 0 of word address 7 with bus_be[0] set clears the lock. Writing 0 there, or writing with bus_be[0] clear, leaves the lock unchanged, and no write can set the lock again.
- R4: When unlocked, pin_oe follows the direction register (address 2, 1 = output) and pin_out follows the output register (address 1). Both take effect on the clock edge that accepts the write.
- R5: When unlocked, pin_pull_en is 1 on pins that are inputs and have the pull enable (address 3) set. On those pins pin_pull_up equals the output register bit (1 = pull-up, 0 = pull-down). On output pins both signals are 0.
- R6: bus_be[0] writes bits 7:0 (port A) and bus_be[1] writes bits 15:8 (port B). A byte whose enable is clear keeps its previous value.
- R7: The input register (address 0, read-only) returns the pin levels two clock edges after they are applied.
- R8: A flag bit (address 6) sets on a rising input transition when its edge-select bit (address 4) is 0, or on a falling transition when it is 1, but only if its interrupt enable (address 5) is 1.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it. If a qualifying transition arrives in the same cycle as the clearing write, the flag stays set.
- R10: Transitions are ignored while the lock is set, and changing an edge-select bit never sets a flag by itself.
- R11: irq is 1 exactly when some bit has both its flag and its interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_be | input | 2 | Byte enables: bit 0 for port A, bit 1 for port B |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, returned combinationally during a read |
| pin_in | input | 16 | Raw pad levels |
| pin_out | output | 16 | Pad drive values |
| pin_oe | output | 16 | Pad output enables |
| pin_pull_en | output | 16 | Pull resistor enables |
| pin_pull_up | output | 16 | Pull polarity (1 = up) |
| irq | output | 1 | Combined interrupt |

## Verification
A configuration write shows on the pad outputs and in the read data right after the clock edge that samples it. A pin level reaches the input register after two edges, and the flag and irq it causes appear after three. The bench drives every input on the falling edge. It waits four falling edges after each pin change and at least one after each write before reading back. It does not sample any result before the edge on which that result is due. The set-over-clear case is driven on a hand-counted schedule, so that the clearing write is sampled on the same edge that registers the new transition.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_INPUT  = 3'd0,
        REG_OUTPUT = 3'd1,
        REG_DIR    = 3'd2,
        REG_PULL   = 3'd3,
        REG_EDGE   = 3'd4,
        REG_IEN    = 3'd5,
        REG_FLAG   = 3'd6,
        REG_CTRL   = 3'd7
    } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign rise_o = hold ? '0 : (st_q.s2 & ~st_q.prev);
    assign fall_o = hold ? '0 : (~st_q.s2 & st_q.prev);

    // R10: no transition is reported while held
    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ((rise_o | fall_o) == '0));
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_pair_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int DW = 2 * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     sync_in,
    input  logic [DW-1:0]     rise_in,
    input  logic [DW-1:0]     fall_in,
    output logic [DW-1:0]     out_o,
    output logic [DW-1:0]     dir_o,
    output logic [DW-1:0]     pull_o,
    output logic [DW-1:0]     ien_o,
    output logic [DW-1:0]     flag_o,
    output logic              lock_o
);
    typedef struct packed {
        logic [DW-1:0] outv;
        logic [DW-1:0] dir;
        logic [DW-1:0] pull;
        logic [DW-1:0] edge_sel;
        logic [DW-1:0] ien;
        logic [DW-1:0] flag;
        logic          locked_n;
    } regs_t;

    regs_t r_d, r_q;
    gpio_reg_e     reg_sel;
    logic          wr_en;
    logic [DW-1:0] bmask;
    logic [DW-1:0] merged_w;
    logic [DW-1:0] hit_edge;
    logic [DW-1:0] clr_v;

    assign reg_sel  = gpio_reg_e'(bus_addr);
    assign wr_en    = bus_sel & bus_wr;
    assign bmask    = {{PORT_W{bus_be[1]}}, {PORT_W{bus_be[0]}}};
    assign hit_edge = (rise_in & ~r_q.edge_sel) | (fall_in & r_q.edge_sel);

    always_comb begin
        r_d   = r_q;
        clr_v = '0;
        if (wr_en) begin
            unique case (reg_sel)
                REG_OUTPUT: r_d.outv     = (r_q.outv & ~bmask) | (bus_wdata & bmask);
                REG_DIR:    r_d.dir      = (r_q.dir & ~bmask) | (bus_wdata & bmask);
                REG_PULL:   r_d.pull     = (r_q.pull & ~bmask) | (bus_wdata & bmask);
                REG_EDGE:   r_d.edge_sel = (r_q.edge_sel & ~bmask) | (bus_wdata & bmask);
                REG_IEN:    r_d.ien      = (r_q.ien & ~bmask) | (bus_wdata & bmask);
                REG_FLAG:   clr_v        = bus_wdata & bmask;
                REG_CTRL: begin
                    if (bus_be[0] && bus_wdata[0]) r_d.locked_n = 1'b1;
                end
                default: ;
            endcase
        end
        r_d.flag = (r_q.flag & ~clr_v) | (hit_edge & r_q.ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        merged_w  = '0;
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_sel)
                REG_INPUT:  bus_rdata = sync_in;
                REG_OUTPUT: bus_rdata = r_q.outv;
                REG_DIR:    bus_rdata = r_q.dir;
                REG_PULL:   bus_rdata = r_q.pull;
                REG_EDGE:   bus_rdata = r_q.edge_sel;
                REG_IEN:    bus_rdata = r_q.ien;
                REG_FLAG:   bus_rdata = r_q.flag;
                REG_CTRL: begin
                    merged_w[0] = ~r_q.locked_n;
                    bus_rdata   = merged_w;
                end
                default: ;
            endcase
        end
    end

    assign out_o  = r_q.outv;
    assign dir_o  = r_q.dir;
    assign pull_o = r_q.pull;
    assign ien_o  = r_q.ien;
    assign flag_o = r_q.flag;
    assign lock_o = ~r_q.locked_n;

    // R3: once cleared the lock never returns without reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |=> !lock_o);
    // R8: a flag can only rise where the enable was set
    p_flag_needs_ien_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_o & ~$past(flag_o) & ~$past(r_q.ien)) == '0));
    // R9: a qualifying transition always leaves its flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(hit_edge & r_q.ien)) == $past(hit_edge & r_q.ien)));
    // R10: no new flag is raised from a locked cycle
    p_locked_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> ((flag_o & ~$past(flag_o)) == '0));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int W = 16
) (
    input  logic         lock,
    input  logic [W-1:0] outv,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pull,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pull_en,
    output logic [W-1:0] pin_pull_up
);
    logic [W-1:0] pen_v;

    always_comb begin
        pen_v = pull & ~dir;
        if (lock) begin
            pin_out     = '0;
            pin_oe      = '0;
            pin_pull_en = '0;
            pin_pull_up = '0;
        end else begin
            pin_out     = outv;
            pin_oe      = dir;
            pin_pull_en = pen_v;
            pin_pull_up = outv & pen_v;
        end
    end
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
    import gpio_pair_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int DW = 2 * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     pin_in,
    output logic [DW-1:0]     pin_out,
    output logic [DW-1:0]     pin_oe,
    output logic [DW-1:0]     pin_pull_en,
    output logic [DW-1:0]     pin_pull_up,
    output logic              irq
);
    logic [DW-1:0] sync_v, rise_v, fall_v;
    logic [DW-1:0] outv, dir, pull, ien, flag;
    logic          lock;

    gpio_in_sync #(.W(DW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (lock),
        .raw_in (pin_in),
        .sync_o (sync_v),
        .rise_o (rise_v),
        .fall_o (fall_v)
    );

    gpio_reg_file #(.PORT_W(PORT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_v),
        .rise_in   (rise_v),
        .fall_in   (fall_v),
        .out_o     (outv),
        .dir_o     (dir),
        .pull_o    (pull),
        .ien_o     (ien),
        .flag_o    (flag),
        .lock_o    (lock)
    );

    gpio_pin_drive #(.W(DW)) u_drive (
        .lock        (lock),
        .outv        (outv),
        .dir         (dir),
        .pull        (pull),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_pull_en (pin_pull_en),
        .pin_pull_up (pin_pull_up)
    );

    assign irq = |(flag & ien);

    // R2: a locked controller drives nothing onto the pads
    p_locked_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (pin_oe == '0 && pin_pull_en == '0 && pin_out == '0));
    // R5: pulls never coexist with an enabled driver
    p_pull_inputs_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pull_en & pin_oe) == '0));
    // R5: pull-up only where a pull is enabled
    p_pullup_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pull_up & ~pin_pull_en) == '0));
endmodule

// File: tb/tb_gpio_pair_ctrl.sv
module tb_gpio_pair_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [15:0] pin_in = '0, pin_out, pin_oe, pin_pull_en, pin_pull_up;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] m_out, m_dir, m_pull, m_edge, m_ien, m_flag, m_pins;
    logic        m_lock;

    always #10 clk = ~clk;

    gpio_pair_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pull_en(pin_pull_en), .pin_pull_up(pin_pull_up),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_of(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] exp_oe();
        return m_lock ? 16'h0 : m_dir;
    endfunction
    function automatic logic [15:0] exp_out();
        return m_lock ? 16'h0 : m_out;
    endfunction
    function automatic logic [15:0] exp_pen();
        return m_lock ? 16'h0 : (m_pull & ~m_dir);
    endfunction
    function automatic logic [15:0] exp_pup();
        return m_lock ? 16'h0 : (m_out & m_pull & ~m_dir);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
        logic [15:0] mk;
        mk = mask_of(be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (a)
            3'd1: m_out  = (m_out  & ~mk) | (d & mk);
            3'd2: m_dir  = (m_dir  & ~mk) | (d & mk);
            3'd3: m_pull = (m_pull & ~mk) | (d & mk);
            3'd4: m_edge = (m_edge & ~mk) | (d & mk);
            3'd5: m_ien  = (m_ien  & ~mk) | (d & mk);
            3'd6: m_flag = m_flag & ~(d & mk);
            3'd7: if (be[0] && d[0]) m_lock = 1'b0;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic set_pins(input logic [15:0] v);
        logic [15:0] hit;
        @(negedge clk);
        pin_in = v;
        if (!m_lock) begin
            hit = ((v & ~m_pins) & ~m_edge) | ((~v & m_pins) & m_edge);
            m_flag = m_flag | (hit & m_ien);
        end
        m_pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [15:0] d;
        @(negedge clk);
        rd(3'd0, d); chk({tag, " R7 input"}, d, m_pins);
        rd(3'd1, d); chk({tag, " R6 out reg"}, d, m_out);
        rd(3'd2, d); chk({tag, " R6 dir reg"}, d, m_dir);
        rd(3'd3, d); chk({tag, " R6 pull reg"}, d, m_pull);
        rd(3'd4, d); chk({tag, " R6 edge reg"}, d, m_edge);
        rd(3'd5, d); chk({tag, " R6 ien reg"}, d, m_ien);
        rd(3'd6, d); chk({tag, " R8 R9 flags"}, d, m_flag);
        rd(3'd7, d); chk({tag, " R3 lock"}, d, {15'd0, m_lock});
        chk({tag, " R4 pin_oe"}, pin_oe, exp_oe());
        chk({tag, " R4 pin_out"}, pin_out, exp_out());
        chk({tag, " R5 pull_en"}, pin_pull_en, exp_pen());
        chk({tag, " R5 pull_up"}, pin_pull_up, exp_pup());
        chk({tag, " R11 irq"}, {15'd0, irq}, {15'd0, |(m_flag & m_ien)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd4242));
        m_out = '0; m_dir = '0; m_pull = '0; m_edge = '0; m_ien = '0;
        m_flag = '0; m_pins = '0; m_lock = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("r1_reset");

        // R2: locked writes stored but pads stay off; R10 no flags while locked
        wr(3'd2, 2'b11, 16'h0F0F);
        wr(3'd1, 2'b11, 16'hFFFF);
        wr(3'd3, 2'b11, 16'hFFFF);
        wr(3'd5, 2'b11, 16'hFFFF);
        set_pins(16'hA5A5);
        set_pins(16'h0000);
        check_all("r2_locked");
        chk("R10 no flag when locked", m_flag, 16'h0);

        // R3: non-clearing writes leave the lock
        wr(3'd7, 2'b11, 16'h0000);
        wr(3'd7, 2'b10, 16'hFFFF);
        check_all("r3_still_locked");
        for (int i = 0; i < 40; i++) begin
            int a;
            a = 1 + ($urandom % 6);
            if ($urandom % 3 == 0) set_pins(16'($urandom));
            else wr(3'(a), 2'($urandom), 16'($urandom));
        end
        check_all("r10_locked_rand");

        // R3: clear the lock
        wr(3'd7, 2'b01, 16'h0001);
        check_all("r3_unlocked");
        wr(3'd7, 2'b11, 16'h0000);
        check_all("r3_no_relock");

        // R6: byte enables
        wr(3'd2, 2'b11, 16'h0000);
        wr(3'd1, 2'b01, 16'h3C5A);
        wr(3'd1, 2'b10, 16'h9911);
        rd(3'd1, d);
        chk("R6 byte merge", d, 16'h995A);
        check_all("r6_bytes");

        // R4/R5 pulls on inputs, R5 off on outputs
        wr(3'd3, 2'b11, 16'hFF00);
        wr(3'd2, 2'b11, 16'hF000);
        check_all("r5_pull");

        // R8/R9: set-wins corner on bit 0
        wr(3'd6, 2'b11, 16'hFFFF);
        wr(3'd4, 2'b11, 16'h0000);
        wr(3'd5, 2'b11, 16'h0001);
        set_pins(16'h0000);
        set_pins(16'h0001);
        check_all("r8_rise");
        set_pins(16'h0000);
        @(negedge clk); pin_in = 16'h0001; m_pins = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_be = 2'b01; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        check_all("r9_set_wins");
        chk("R9 flag kept", m_flag, 16'h0001);
        wr(3'd6, 2'b01, 16'h0001);
        check_all("r9_clear");

        // R10: edge-select change alone sets nothing
        wr(3'd5, 2'b11, 16'h0003);
        set_pins(16'h0003);
        wr(3'd6, 2'b11, 16'hFFFF);
        wr(3'd4, 2'b11, 16'h0003);
        repeat (3) @(negedge clk);
        check_all("r10_edge_sel");
        set_pins(16'h0000);
        check_all("r8_fall");

        // Random unlocked traffic
        for (int i = 0; i < 250; i++) begin
            int a;
            a = 1 + ($urandom % 6);
            if ($urandom % 2 == 0) set_pins(16'($urandom));
            else wr(3'(a), 2'($urandom), 16'($urandom));
            if (i % 5 == 0) check_all("rand_r8_r11");
        end
        check_all("rand_end");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule